// File: doc/BRIEF.md
# Decoded Instruction Chunk Matcher

This block decides whether the bytes now being fetched for an instruction are the same bytes that produced an instruction decoded earlier. It holds a small set of entries. Each entry keeps a list of fetch chunks, one byte mask per chunk, the byte offset at which the instruction ends inside its last chunk, and a flag that says whether the entry still has a usable decoded result. An instruction may start at any byte of its first chunk and run across several chunks. The masks limit the compare to the bytes that belong to it.

A lookup names an entry and gives the instruction's program counter. The matcher then takes fetched chunks one at a time over a valid/ready handshake. It masks each chunk, compares it with the stored chunk and then does one of three things: it asks for the next chunk, it reports a hit with the end offset, or it reports a miss. On a miss it hands control back to the byte-level decoder and gives the byte offset from which decoding restarts. The mismatching chunk overwrites the stored one, the list is cut just after it and the entry is marked unusable. The byte decoder can append more chunks later and then commit the entry, which builds the masks and clears every stored byte that lies outside them.

The choice of entry and the decoded payload belong to the surrounding logic.

Top module: `chunk_match_top`

## Requirements
- R1: After reset, hit, miss, next_req, need_bytes, lk_busy and fc_ready are all low.
- R2: A fetched chunk is accepted when fc_valid and fc_ready are both high. The chunk is ANDed with the stored mask for the current chunk index and compared with the stored chunk. Bytes outside the mask never affect the result.
- R3: A match on a chunk other than the last stored one makes next_req high for exactly the cycle after the accepting edge. The index moves to the next chunk and fc_ready stays high.
- R4: A match on the last stored chunk makes hit high for exactly the cycle after the accepting edge. hit_off then carries the stored end offset (1 to CHUNK_BYTES), and need_bytes is high in that same cycle only if the offset equals CHUNK_BYTES.
- R5: A mismatch makes miss high for exactly the cycle after the accepting edge. restart_off then equals lk_pc modulo CHUNK_BYTES (the low three bits with the default 8-byte chunk), and the lookup ends.
- R6: On a mismatch at index i, the fetched chunk replaces stored chunk i, the entry's chunk count becomes i+1, and the entry is marked as having no usable result.
- R7: A lookup of an entry with no usable result gives a miss in the cycle after lk_start. It consumes no chunk, and fc_ready stays low.
- R8: On commit, byte lane b of chunk k is in the mask exactly when the global position k*CHUNK_BYTES+b is at least fill_first_off and below (count-1)*CHUNK_BYTES+fill_last_off. The first chunk therefore starts at the start offset, and later chunks start at lane 0.
- R9: On commit, every stored chunk is ANDed with its new mask, and the entry is marked usable.
- R10: An append with app_first high restarts the entry's list with that chunk as chunk 0. An append without it adds the chunk at the current count. Either kind of append marks the entry unusable until the next commit.
- R11: fc_ready is high only while a lookup is comparing, and fc_valid has no effect while fc_ready is low.
- R12: Entries are independent. A miss or an append on one entry leaves the lookup result of every other entry unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_start | input | 1 | Start a lookup (taken while lk_busy is low) |
| lk_entry | input | EW | Entry to look up |
| lk_pc | input | PC_W | Program counter of the instruction |
| lk_busy | output | 1 | A lookup is comparing chunks |
| fc_valid | input | 1 | Fetched chunk present |
| fc_ready | output | 1 | Matcher takes a fetched chunk |
| fc_data | input | 8*CHUNK_BYTES | Fetched chunk, byte lane b at bits 8b+7:8b |
| hit | output | 1 | One-cycle pulse: all chunks matched |
| hit_off | output | OFF_W | End offset of the instruction in its last chunk |
| need_bytes | output | 1 | With hit: the instruction used the whole last chunk |
| next_req | output | 1 | One-cycle pulse: send the next chunk |
| miss | output | 1 | One-cycle pulse: hand over to the byte decoder |
| restart_off | output | LANE_W | Byte offset for restarting the decode |
| app_valid | input | 1 | Append a chunk to an entry |
| app_entry | input | EW | Entry to append to |
| app_first | input | 1 | Restart the list with this chunk |
| app_data | input | 8*CHUNK_BYTES | Chunk to append |
| fill_valid | input | 1 | Commit an entry and build its masks |
| fill_entry | input | EW | Entry to commit |
| fill_first_off | input | LANE_W | Byte offset of the instruction start in chunk 0 |
| fill_last_off | input | OFF_W | End offset in the last chunk (1 to CHUNK_BYTES) |

## Verification
A stored mask built one lane too wide or too narrow shows up at the first lookup that changes a byte at the edge of the instruction. That lookup gives a miss where a hit was due, or the reverse, one cycle after the faulty chunk is accepted. A wrong chunk index or count appears as next_req in place of hit, or hit in place of next_req, on the chunk where the boundary falls. A missed invalidation or truncation after a mismatch appears at the next lookup of that entry. That lookup must miss at once without taking a chunk, and after a commit it must hit on the replaced chunk with the shorter list. A bad restart offset or end offset shows directly on restart_off or hit_off in the pulse cycle.

// File: rtl/chunk_match_pkg.sv
package chunk_match_pkg;

  typedef enum logic {
    CM_IDLE,
    CM_CMP
  } cm_state_t;

  // Whether byte lane b of chunk k belongs to the instruction. The span is
  // global: from first_off in chunk 0 up to last_off in chunk cnt-1.
  function automatic logic lane_live(input int k, input int b, input int cnt,
                                     input int first_off, input int last_off,
                                     input int cb);
    int pos;
    pos = k * cb + b;
    return (k < cnt) && (pos >= first_off) && (pos < (cnt - 1) * cb + last_off);
  endfunction

endpackage

// File: rtl/chunk_mask_gen.sv
module chunk_mask_gen #(
  parameter int CHUNK_BYTES = 8,
  parameter int MAX_CHUNKS  = 4,
  localparam int DW     = 8 * CHUNK_BYTES,
  localparam int CNT_W  = $clog2(MAX_CHUNKS + 1),
  localparam int LANE_W = $clog2(CHUNK_BYTES),
  localparam int OFF_W  = $clog2(CHUNK_BYTES) + 1
) (
  input  logic [CNT_W-1:0]                 count,
  input  logic [LANE_W-1:0]                first_off,
  input  logic [OFF_W-1:0]                 last_off,
  output logic [MAX_CHUNKS-1:0][DW-1:0]    masks
);
  import chunk_match_pkg::*;

  for (genvar k = 0; k < MAX_CHUNKS; k++) begin : g_chunk
    for (genvar b = 0; b < CHUNK_BYTES; b++) begin : g_lane
      assign masks[k][b*8 +: 8] = {8{lane_live(k, b, int'(count), int'(first_off),
                                               int'(last_off), CHUNK_BYTES)}};
    end
  end

endmodule

// File: rtl/chunk_entry_store.sv
module chunk_entry_store #(
  parameter int NUM_ENTRIES = 4,
  parameter int MAX_CHUNKS  = 4,
  parameter int CHUNK_BYTES = 8,
  localparam int DW     = 8 * CHUNK_BYTES,
  localparam int EW     = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int IW     = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1,
  localparam int CNT_W  = $clog2(MAX_CHUNKS + 1),
  localparam int LANE_W = $clog2(CHUNK_BYTES),
  localparam int OFF_W  = $clog2(CHUNK_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [EW-1:0]     rd_entry,
  input  logic [IW-1:0]     rd_idx,
  output logic [DW-1:0]     rd_chunk,
  output logic [DW-1:0]     rd_mask,
  output logic [CNT_W-1:0]  rd_count,
  output logic [OFF_W-1:0]  rd_last,
  output logic              rd_valid,
  input  logic              miss_we,
  input  logic [EW-1:0]     miss_entry,
  input  logic [IW-1:0]     miss_idx,
  input  logic [DW-1:0]     miss_data,
  input  logic              fill_we,
  input  logic [EW-1:0]     fill_entry,
  input  logic [LANE_W-1:0] fill_first,
  input  logic [OFF_W-1:0]  fill_last,
  input  logic              app_we,
  input  logic [EW-1:0]     app_entry,
  input  logic              app_first,
  input  logic [DW-1:0]     app_data
);

  logic [NUM_ENTRIES-1:0][MAX_CHUNKS-1:0][DW-1:0] chunk_q;
  logic [NUM_ENTRIES-1:0][MAX_CHUNKS-1:0][DW-1:0] mask_q;
  logic [NUM_ENTRIES-1:0][CNT_W-1:0]              count_q;
  logic [NUM_ENTRIES-1:0][OFF_W-1:0]              last_q;
  logic [NUM_ENTRIES-1:0]                         valid_q;

  logic [MAX_CHUNKS-1:0][DW-1:0] fill_masks;
  logic [CNT_W-1:0]              fill_count;

  assign fill_count = count_q[fill_entry];

  chunk_mask_gen #(
    .CHUNK_BYTES(CHUNK_BYTES),
    .MAX_CHUNKS (MAX_CHUNKS)
  ) u_mask_gen (
    .count    (fill_count),
    .first_off(fill_first),
    .last_off (fill_last),
    .masks    (fill_masks)
  );

  assign rd_chunk = chunk_q[rd_entry][rd_idx];
  assign rd_mask  = mask_q[rd_entry][rd_idx];
  assign rd_count = count_q[rd_entry];
  assign rd_last  = last_q[rd_entry];
  assign rd_valid = valid_q[rd_entry];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chunk_q <= '0;
      mask_q  <= '0;
      count_q <= '0;
      last_q  <= '0;
      valid_q <= '0;
    end else begin
      for (int e = 0; e < NUM_ENTRIES; e++) begin
        if (miss_we && (int'(miss_entry) == e)) begin
          chunk_q[e][miss_idx] <= miss_data;
          count_q[e]           <= CNT_W'(miss_idx) + CNT_W'(1);
          valid_q[e]           <= 1'b0;
        end else if (fill_we && (int'(fill_entry) == e) && (count_q[e] != '0)) begin
          for (int k = 0; k < MAX_CHUNKS; k++) begin
            chunk_q[e][k] <= chunk_q[e][k] & fill_masks[k];
            mask_q[e][k]  <= fill_masks[k];
          end
          last_q[e]  <= fill_last;
          valid_q[e] <= 1'b1;
        end else if (app_we && (int'(app_entry) == e)) begin
          if (app_first) begin
            chunk_q[e][0] <= app_data;
            count_q[e]    <= CNT_W'(1);
            valid_q[e]    <= 1'b0;
          end else if (int'(count_q[e]) < MAX_CHUNKS) begin
            chunk_q[e][IW'(count_q[e])] <= app_data;
            count_q[e]                  <= count_q[e] + CNT_W'(1);
            valid_q[e]                  <= 1'b0;
          end
        end
      end
    end
  end

  // R6
  miss_invalidates_chk: assert property (@(posedge clk) disable iff (!rst_n)
    miss_we |=> !valid_q[$past(miss_entry)]);

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_bound
    // R10
    count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(count_q[e]) <= MAX_CHUNKS);
    // R9
    valid_has_chunks_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_q[e] |-> (count_q[e] != '0));
  end

endmodule

// File: rtl/chunk_match_ctrl.sv
module chunk_match_ctrl #(
  parameter int NUM_ENTRIES = 4,
  parameter int MAX_CHUNKS  = 4,
  parameter int CHUNK_BYTES = 8,
  parameter int PC_W        = 32,
  localparam int DW     = 8 * CHUNK_BYTES,
  localparam int EW     = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int IW     = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1,
  localparam int CNT_W  = $clog2(MAX_CHUNKS + 1),
  localparam int LANE_W = $clog2(CHUNK_BYTES),
  localparam int OFF_W  = $clog2(CHUNK_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_start,
  input  logic [EW-1:0]     lk_entry,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_busy,
  input  logic              fc_valid,
  output logic              fc_ready,
  input  logic [DW-1:0]     fc_data,
  output logic              hit,
  output logic [OFF_W-1:0]  hit_off,
  output logic              need_bytes,
  output logic              next_req,
  output logic              miss,
  output logic [LANE_W-1:0] restart_off,
  output logic [EW-1:0]     rd_entry,
  output logic [IW-1:0]     rd_idx,
  input  logic [DW-1:0]     rd_chunk,
  input  logic [DW-1:0]     rd_mask,
  input  logic [CNT_W-1:0]  rd_count,
  input  logic [OFF_W-1:0]  rd_last,
  input  logic              rd_valid,
  output logic              miss_we,
  output logic [EW-1:0]     miss_entry,
  output logic [IW-1:0]     miss_idx,
  output logic [DW-1:0]     miss_data
);
  import chunk_match_pkg::*;

  cm_state_t         st_q;
  logic [EW-1:0]     entry_q;
  logic [IW-1:0]     idx_q;
  logic [LANE_W-1:0] pcoff_q;
  logic              hit_q, miss_q, next_q, need_q;
  logic [OFF_W-1:0]  hit_off_q;
  logic [LANE_W-1:0] roff_q;

  // Named internal events
  logic              fc_take;
  logic              chunk_eq;
  logic              at_last;
  logic [LANE_W-1:0] start_off;

  assign lk_busy   = (st_q == CM_CMP);
  assign fc_ready  = lk_busy;
  assign fc_take   = fc_valid && fc_ready;
  assign chunk_eq  = ((fc_data & rd_mask) == rd_chunk);
  assign at_last   = ((CNT_W'(idx_q) + CNT_W'(1)) == rd_count);
  assign start_off = LANE_W'(lk_pc % PC_W'(CHUNK_BYTES));

  assign rd_entry  = lk_busy ? entry_q : lk_entry;
  assign rd_idx    = idx_q;

  assign miss_we    = fc_take && !chunk_eq;
  assign miss_entry = entry_q;
  assign miss_idx   = idx_q;
  assign miss_data  = fc_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= CM_IDLE;
      entry_q   <= '0;
      idx_q     <= '0;
      pcoff_q   <= '0;
      hit_q     <= 1'b0;
      miss_q    <= 1'b0;
      next_q    <= 1'b0;
      need_q    <= 1'b0;
      hit_off_q <= '0;
      roff_q    <= '0;
    end else begin
      hit_q  <= 1'b0;
      miss_q <= 1'b0;
      next_q <= 1'b0;
      need_q <= 1'b0;
      case (st_q)
        CM_IDLE: begin
          if (lk_start) begin
            entry_q <= lk_entry;
            idx_q   <= '0;
            pcoff_q <= start_off;
            if (rd_valid) begin
              st_q <= CM_CMP;
            end else begin
              miss_q <= 1'b1;
              roff_q <= start_off;
            end
          end
        end
        CM_CMP: begin
          if (fc_take) begin
            if (!chunk_eq) begin
              miss_q <= 1'b1;
              roff_q <= pcoff_q;
              st_q   <= CM_IDLE;
            end else if (at_last) begin
              hit_q     <= 1'b1;
              hit_off_q <= rd_last;
              need_q    <= (int'(rd_last) == CHUNK_BYTES);
              st_q      <= CM_IDLE;
            end else begin
              next_q <= 1'b1;
              idx_q  <= idx_q + IW'(1);
            end
          end
        end
        default: st_q <= CM_IDLE;
      endcase
    end
  end

  assign hit         = hit_q;
  assign miss        = miss_q;
  assign next_req    = next_q;
  assign need_bytes  = need_q;
  assign hit_off     = hit_off_q;
  assign restart_off = roff_q;

  // R4
  need_with_full_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    need_bytes |-> (hit && (int'(hit_off) == CHUNK_BYTES)));
  // R5
  hit_miss_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hit && miss));
  // R4
  result_ends_lookup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hit || miss) |-> !lk_busy);
  // R3
  next_keeps_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    next_req |-> lk_busy);
  // R3
  idx_in_list_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lk_busy |-> (CNT_W'(idx_q) < rd_count));
  // R11
  ready_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lk_busy && !$past(lk_busy)) |-> !(hit || next_req));

endmodule

// File: rtl/chunk_match_top.sv
module chunk_match_top #(
  parameter int NUM_ENTRIES = 4,
  parameter int MAX_CHUNKS  = 4,
  parameter int CHUNK_BYTES = 8,
  parameter int PC_W        = 32,
  localparam int DW     = 8 * CHUNK_BYTES,
  localparam int EW     = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1,
  localparam int IW     = (MAX_CHUNKS > 1) ? $clog2(MAX_CHUNKS) : 1,
  localparam int CNT_W  = $clog2(MAX_CHUNKS + 1),
  localparam int LANE_W = $clog2(CHUNK_BYTES),
  localparam int OFF_W  = $clog2(CHUNK_BYTES) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lk_start,
  input  logic [EW-1:0]     lk_entry,
  input  logic [PC_W-1:0]   lk_pc,
  output logic              lk_busy,
  input  logic              fc_valid,
  output logic              fc_ready,
  input  logic [DW-1:0]     fc_data,
  output logic              hit,
  output logic [OFF_W-1:0]  hit_off,
  output logic              need_bytes,
  output logic              next_req,
  output logic              miss,
  output logic [LANE_W-1:0] restart_off,
  input  logic              app_valid,
  input  logic [EW-1:0]     app_entry,
  input  logic              app_first,
  input  logic [DW-1:0]     app_data,
  input  logic              fill_valid,
  input  logic [EW-1:0]     fill_entry,
  input  logic [LANE_W-1:0] fill_first_off,
  input  logic [OFF_W-1:0]  fill_last_off
);

  logic [EW-1:0]    rd_entry;
  logic [IW-1:0]    rd_idx;
  logic [DW-1:0]    rd_chunk, rd_mask;
  logic [CNT_W-1:0] rd_count;
  logic [OFF_W-1:0] rd_last;
  logic             rd_valid;
  logic             miss_we;
  logic [EW-1:0]    miss_entry;
  logic [IW-1:0]    miss_idx;
  logic [DW-1:0]    miss_data;

  chunk_match_ctrl #(
    .NUM_ENTRIES(NUM_ENTRIES), .MAX_CHUNKS(MAX_CHUNKS),
    .CHUNK_BYTES(CHUNK_BYTES), .PC_W(PC_W)
  ) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .lk_start   (lk_start),
    .lk_entry   (lk_entry),
    .lk_pc      (lk_pc),
    .lk_busy    (lk_busy),
    .fc_valid   (fc_valid),
    .fc_ready   (fc_ready),
    .fc_data    (fc_data),
    .hit        (hit),
    .hit_off    (hit_off),
    .need_bytes (need_bytes),
    .next_req   (next_req),
    .miss       (miss),
    .restart_off(restart_off),
    .rd_entry   (rd_entry),
    .rd_idx     (rd_idx),
    .rd_chunk   (rd_chunk),
    .rd_mask    (rd_mask),
    .rd_count   (rd_count),
    .rd_last    (rd_last),
    .rd_valid   (rd_valid),
    .miss_we    (miss_we),
    .miss_entry (miss_entry),
    .miss_idx   (miss_idx),
    .miss_data  (miss_data)
  );

  chunk_entry_store #(
    .NUM_ENTRIES(NUM_ENTRIES), .MAX_CHUNKS(MAX_CHUNKS), .CHUNK_BYTES(CHUNK_BYTES)
  ) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .rd_entry  (rd_entry),
    .rd_idx    (rd_idx),
    .rd_chunk  (rd_chunk),
    .rd_mask   (rd_mask),
    .rd_count  (rd_count),
    .rd_last   (rd_last),
    .rd_valid  (rd_valid),
    .miss_we   (miss_we),
    .miss_entry(miss_entry),
    .miss_idx  (miss_idx),
    .miss_data (miss_data),
    .fill_we   (fill_valid),
    .fill_entry(fill_entry),
    .fill_first(fill_first_off),
    .fill_last (fill_last_off),
    .app_we    (app_valid),
    .app_entry (app_entry),
    .app_first (app_first),
    .app_data  (app_data)
  );

  // R1
  no_pulse_idle_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !(hit || miss || next_req));

endmodule

// File: tb/tb_chunk_match_top.sv
`timescale 1ns/1ps
module tb_chunk_match_top;
  localparam int CB = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        lk_start = 0;
  logic [1:0]  lk_entry = 0;
  logic [31:0] lk_pc = 0;
  logic        lk_busy;
  logic        fc_valid = 0;
  logic        fc_ready;
  logic [63:0] fc_data = 0;
  logic        hit;
  logic [3:0]  hit_off;
  logic        need_bytes, next_req, miss;
  logic [2:0]  restart_off;
  logic        app_valid = 0;
  logic [1:0]  app_entry = 0;
  logic        app_first = 0;
  logic [63:0] app_data = 0;
  logic        fill_valid = 0;
  logic [1:0]  fill_entry = 0;
  logic [2:0]  fill_first_off = 0;
  logic [3:0]  fill_last_off = 0;

  chunk_match_top dut (.*);

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  localparam logic [63:0] B0 = 64'hA8A7A6A5A4A3A2A1;
  localparam logic [63:0] B1 = 64'hB8B7B6B5B4B3B2B1;
  localparam logic [63:0] B2 = 64'hC8C7C6C5C4C3C2C1;

  // {lane(8), expect_miss(1), outcome_chunk(3)}; lane 255 = no change.
  // Entry: 3 chunks, start offset 5, end offset 3 -> live lanes 5..18.
  localparam logic [11:0] VEC [0:10] = '{
    {8'd4,   1'b0, 3'd2}, {8'd5,  1'b1, 3'd0}, {8'd7,  1'b1, 3'd0},
    {8'd8,   1'b1, 3'd1}, {8'd12, 1'b1, 3'd1}, {8'd15, 1'b1, 3'd1},
    {8'd16,  1'b1, 3'd2}, {8'd18, 1'b1, 3'd2}, {8'd19, 1'b0, 3'd2},
    {8'd23,  1'b0, 3'd2}, {8'd255,1'b0, 3'd2}
  };

  // Mask built chunk by chunk from a running byte count.
  function automatic logic [63:0] ref_mask(input int k, input int cnt, input int f, input int l);
    int total, start, sz, e;
    logic [63:0] m;
    total = l - f + (cnt - 1) * CB;
    start = f;
    m = '0;
    for (int i = 0; i <= k && i < cnt; i++) begin
      e = (start + total > CB) ? CB : start + total;
      sz = e - start;
      m = '0;
      for (int b = start; b < e; b++) m[b*8 +: 8] = 8'hFF;
      total -= sz;
      start = 0;
    end
    return m;
  endfunction

  task automatic append(input int e, input bit first, input logic [63:0] d);
    app_valid = 1; app_entry = 2'(e); app_first = first; app_data = d;
    @(negedge clk);
    app_valid = 0; app_first = 0;
  endtask

  task automatic commit(input int e, input int f, input int l);
    fill_valid = 1; fill_entry = 2'(e); fill_first_off = 3'(f); fill_last_off = 4'(l);
    @(negedge clk);
    fill_valid = 0;
  endtask

  task automatic start(input int e, input logic [31:0] pc);
    lk_start = 1; lk_entry = 2'(e); lk_pc = pc;
    @(negedge clk);
    lk_start = 0;
  endtask

  task automatic fetch(input logic [63:0] d);
    fc_valid = 1; fc_data = d;
    @(negedge clk);
    fc_valid = 0;
  endtask

  task automatic prog3(input int e);
    append(e, 1, B0); append(e, 0, B1); append(e, 0, B2);
    commit(e, 5, 3);
  endtask

  initial begin
    #(4 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", n_chk - n_fail + 1, n_chk + 1);
    $finish;
  end

  initial begin
    logic [63:0] d [0:2];
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 hit", hit, 0); chk("R1 miss", miss, 0); chk("R1 next_req", next_req, 0);
    chk("R1 need_bytes", need_bytes, 0); chk("R1 busy", lk_busy, 0); chk("R1 ready", fc_ready, 0);
    rst_n = 1;
    @(negedge clk);

    // R8 mask restatement sanity (bench-side)
    chk("R8 ref mask0", ref_mask(0, 3, 5, 3), 64'hFFFFFF0000000000);
    chk("R8 ref mask2", ref_mask(2, 3, 5, 3), 64'h0000000000FFFFFF);

    // Vector table: R2 R3 R4 R5 R6 R8 R9
    for (int r = 0; r < 11; r++) begin
      int lane;
      bit exp_miss;
      int oc;
      logic [31:0] pc;
      lane = int'(VEC[r][11:4]); exp_miss = VEC[r][3]; oc = int'(VEC[r][2:0]);
      pc = 32'h4000 + 32'(r * 3);
      prog3(0);
      d[0] = B0; d[1] = B1; d[2] = B2;
      if (lane < 24) d[lane / 8] = d[lane / 8] ^ (64'hFF << ((lane % 8) * 8));
      start(0, pc);
      chk("R11 ready during lookup", fc_ready, 1);
      for (int k = 0; k <= oc; k++) begin
        fetch(d[k]);
        if (k < oc) begin
          chk("R3 next_req", next_req, 1);
          chk("R3 no hit/miss", {hit, miss}, 0);
          chk("R3 ready kept", fc_ready, 1);
        end else if (exp_miss) begin
          chk("R5 miss", {miss, hit}, 2'b10);
          chk("R5 restart_off", restart_off, pc % CB);
          chk("R5 lookup ended", fc_ready, 0);
        end else begin
          chk("R2 R9 R4 hit", {hit, miss}, 2'b10);
          chk("R4 hit_off", hit_off, 3);
          chk("R4 need_bytes", need_bytes, 0);
        end
      end
      @(negedge clk);
      chk("R4 R5 one-cycle pulse", {hit, miss, next_req}, 0);
    end

    // R7 entry never committed: immediate miss, no chunk taken
    start(3, 32'h0000_0016);
    chk("R7 miss", miss, 1);
    chk("R7 restart_off", restart_off, 6);
    chk("R7 no ready", fc_ready, 0);

    // R4 full last chunk -> need_bytes
    append(1, 1, 64'h1111111111111111); append(1, 0, 64'h2222222222222222);
    commit(1, 2, 8);
    start(1, 32'h0000_100A);
    fetch(64'h1111111111111111);
    chk("R3 next_req entry1", next_req, 1);
    fetch(64'h2222222222222222);
    chk("R4 hit full", hit, 1);
    chk("R4 hit_off 8", hit_off, 8);
    chk("R4 need_bytes set", need_bytes, 1);

    // R6 miss at index 1 replaces and truncates
    prog3(0);
    start(0, 32'h5);
    fetch(B0);
    fetch(64'h0123456789ABCDEF);
    chk("R6 miss at 1", miss, 1);
    start(0, 32'h5);
    chk("R6 invalidated", miss, 1);
    commit(0, 5, 3);
    start(0, 32'h5);
    fetch(B0);
    chk("R6 next after refill", next_req, 1);
    fetch(64'h0123456789ABCDEF);
    chk("R6 hit on replaced chunk, list cut to 2", hit, 1);

    // R12 entry1 unaffected by entry0 activity
    start(1, 32'h0000_100A);
    fetch(64'h1111111111111111);
    fetch(64'h2222222222222222);
    chk("R12 entry1 still hits", hit, 1);

    // R10 append with restart flag
    append(1, 1, 64'h00000000DEADBEEF);
    start(1, 0);
    chk("R10 append invalidates", miss, 1);
    commit(1, 0, 4);
    start(1, 0);
    fetch(64'hFFFFFFFFDEADBEEF);
    chk("R10 single-chunk hit", hit, 1);
    chk("R10 no next_req", next_req, 0);
    chk("R10 hit_off", hit_off, 4);

    // R11 fc_valid while idle has no effect
    fetch(64'h0);
    chk("R11 idle fetch ignored", {hit, miss, next_req}, 0);
    start(1, 0);
    fetch(64'h00000000DEADBEEF);
    chk("R11 lookup after idle fetch", hit, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule